// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block places a small cache between a processor port that reads or writes one word per request and a slower memory port that moves whole blocks. Each request is a single-cycle pulse, accepted while the controller is idle. The controller splits the word address into a word offset, a set index and a tag, and compares the tag against every way of the selected set. A hit is served from the cache. A miss brings the whole block in from memory before the request is answered. A dirty victim is first written back when the controller is built for write-back.

Three parameters pick the variant. `WAYS` sets the associativity: one way gives a direct-mapped cache, and `WAYS == LINES` gives a fully associative one. `WRITE_BACK` picks write-back, where a write miss allocates and each line has a dirty bit, or write-through, where a write miss does not allocate. `USE_LRU` picks least-recently-used or first-in-first-out victim choice. Two free-running counters give the hit ratio as hits / (hits + misses).

Top module: `assoc_cache`

## Requirements
- R1: Address fields: the word offset is `cpu_addr[1:0]` (default four words per line). The block number is `cpu_addr >> 2`, and the set is the block number modulo the set count. The tag is the bits above the set field. Every memory access presents a block number on `mem_blk`: the requested block for a fill, and the victim's own block for an eviction.
- R2: A read hit returns the word with no memory request. `cpu_done` is high in the second cycle after the cycle in which `cpu_req` was sampled.
- R3: A read miss reads the whole containing block from memory and returns the addressed word from it. Later reads of any word of that block hit.
- R4: In write-through mode every write, hit or miss, issues one memory write. That write carries the word replicated on `mem_wdata`, and `mem_wstrb` is one-hot at bit position equal to the word offset. A write hit also updates the cached copy.
- R5: In write-through mode a write miss leaves the cache unchanged, so a following read of that address misses.
- R6: In write-back mode a write hit updates only the cache and sets the line's dirty bit. The memory word keeps its old value until the line is evicted.
- R7: In write-back mode evicting a dirty line writes the full line (`mem_wstrb` all ones) to the victim's block before the new block is read. A clean victim causes no memory write.
- R8: In write-back mode a write miss fetches the block, merges the written word, and marks the line dirty. A following read of that address hits.
- R9: Within a set, an invalid way is always filled before any valid way is evicted.
- R10: With `USE_LRU=1` the victim is the way least recently hit or filled. With `USE_LRU=0` it is the way filled longest ago, whatever hits occurred since.
- R11: Each completed request adds exactly one to either `hit_count` or `miss_count`, never to both.
- R12: After reset both counters are zero, every line is invalid so the first access misses, `cpu_ready` is high and `cpu_done` is low.
- R13: `mem_req`, `mem_we` and `mem_blk` stay asserted and unchanged from the start of a memory access until the cycle in which `mem_ack` is seen.
- R14: `cpu_done` is a one-cycle pulse. `cpu_ready` drops in the cycle after a request is accepted and stays low until the request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse, honoured while `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle, request may be issued |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` for reads |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_blk | output | ADDR_W-log2(WORDS_PER_LINE) | Block number |
| mem_wdata | output | WORDS_PER_LINE*DATA_W | Write data, word 0 in the low bits |
| mem_wstrb | output | WORDS_PER_LINE | Per-word write enables |
| mem_ack | input | 1 | One-cycle acknowledge ending the access |
| mem_rdata | input | WORDS_PER_LINE*DATA_W | Block read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A request sampled at one clock edge reaches the tag compare on the next edge. On a hit, the compare registers `cpu_done` and the read data, so a hit answers in the second cycle and the bench requires exactly that cycle count with no memory request in between. A miss adds the memory latency for each access it makes: one write-back for a dirty victim, then one block read. For those the bench only requires that a memory request appeared, and it checks data and counters when `cpu_done` shows. All sampling happens on falling edges, and the bench counts falling edges from the request. It reads the memory-side contents and strobe history only after both controllers have reported completion.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } cache_state_e;

endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           req_tag,
    output logic [WAYS-1:0]            match,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    // one comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_repl.sv
module cache_repl #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] sel_set,
    input  logic [WAYS-1:0]  sel_valid,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);

    // age 0 = most recent, WAYS-1 = next victim; each set holds a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] age_d [SETS][WAYS];

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_d[sel_set][w] = '0;
                end else if (age_q[sel_set][w] < age_q[sel_set][touch_way]) begin
                    age_d[sel_set][w] = age_q[sel_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!sel_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[sel_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            age_q <= age_d;
        end
    end

    // R9: an empty way is chosen whenever the set has one
    a_r9_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sel_valid)) |-> !sel_valid[victim_way]);

endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_pulse,
    input  logic             miss_pulse,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);

    typedef struct packed {
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit_pulse)  cnt_d.hits   = cnt_q.hits + 1'b1;
        if (miss_pulse) cnt_d.misses = cnt_q.misses + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_count  = cnt_q.hits;
    assign miss_count = cnt_q.misses;

    // R11: a lookup is classified once
    a_r11_single_class: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_pulse && miss_pulse));

    a_r11_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |=> hit_count == $past(hit_count) + 1'b1);

    a_r11_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> miss_count == $past(miss_count) + 1'b1);

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int DATA_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 8,
    parameter int WAYS           = 2,
    parameter bit WRITE_BACK     = 1'b1,
    parameter bit USE_LRU        = 1'b1,
    parameter int CNT_W          = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cpu_req,
    input  logic                                     cpu_we,
    input  logic [ADDR_W-1:0]                        cpu_addr,
    input  logic [DATA_W-1:0]                        cpu_wdata,
    output logic                                     cpu_ready,
    output logic                                     cpu_done,
    output logic [DATA_W-1:0]                        cpu_rdata,
    output logic                                     mem_req,
    output logic                                     mem_we,
    output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] mem_blk,
    output logic [WORDS_PER_LINE*DATA_W-1:0]         mem_wdata,
    output logic [WORDS_PER_LINE-1:0]                mem_wstrb,
    input  logic                                     mem_ack,
    input  logic [WORDS_PER_LINE*DATA_W-1:0]         mem_rdata,
    output logic [CNT_W-1:0]                         hit_count,
    output logic [CNT_W-1:0]                         miss_count
);

    localparam int OFF_W  = $clog2(WORDS_PER_LINE);
    localparam int SETS   = LINES / WAYS;
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 0;
    localparam int SET_W  = (SETS > 1) ? IDX_W : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = WORDS_PER_LINE * DATA_W;

    typedef struct packed {
        cache_state_e      state;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [WAY_W-1:0]  vic;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [LINE_W-1:0] data_q [LINES];
    logic [LINE_W-1:0] data_d [LINES];
    logic [LINES-1:0]  valid_q, valid_d;
    logic [LINES-1:0]  dirty_q, dirty_d;

    // fields of the latched request
    logic [OFF_W-1:0] req_off;
    logic [BLK_W-1:0] req_blk;
    logic [SET_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;

    assign req_off = ctl_q.addr[OFF_W-1:0];
    assign req_blk = ctl_q.addr[ADDR_W-1:OFF_W];
    assign req_set = SET_W'(req_blk % BLK_W'(SETS));
    assign req_tag = TAG_W'(req_blk >> IDX_W);

    // gather the ways of the selected set
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w]  = tag_q[int'(req_set) * WAYS + w];
            set_valid[w] = valid_q[int'(req_set) * WAYS + w];
        end
    end

    logic [WAYS-1:0]  match;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic             hit_pulse;
    logic             miss_pulse;

    cache_lookup #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_lookup (
        .way_tag   (set_tags),
        .way_valid (set_valid),
        .req_tag   (req_tag),
        .match     (match),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_repl #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_set    (req_set),
        .sel_valid  (set_valid),
        .victim_way (victim_way),
        .touch_en   (touch_en),
        .touch_way  (touch_way)
    );

    cache_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_pulse  (hit_pulse),
        .miss_pulse (miss_pulse),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // next-state logic
    always_comb begin
        int               hl;
        int               vl;
        logic [LINE_W-1:0] line;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tag_d      = tag_q;
        data_d     = data_q;
        valid_d    = valid_q;
        dirty_d    = dirty_q;
        hit_pulse  = 1'b0;
        miss_pulse = 1'b0;
        touch_en   = 1'b0;
        touch_way  = hit_way;
        hl         = int'(req_set) * WAYS + int'(hit_way);
        vl         = int'(req_set) * WAYS + int'(ctl_q.vic);
        line       = mem_rdata;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.we    = cpu_we;
                    ctl_d.addr  = cpu_addr;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.state = ST_TAG;
                end
            end

            ST_TAG: begin
                if (hit) begin
                    hit_pulse = 1'b1;
                    touch_en  = USE_LRU;
                    if (ctl_q.we) begin
                        data_d[hl][int'(req_off)*DATA_W +: DATA_W] = ctl_q.wdata;
                        if (WRITE_BACK) begin
                            dirty_d[hl] = 1'b1;
                            ctl_d.done  = 1'b1;
                            ctl_d.state = ST_IDLE;
                        end else begin
                            ctl_d.state = ST_WTHRU;
                        end
                    end else begin
                        ctl_d.rdata = data_q[hl][int'(req_off)*DATA_W +: DATA_W];
                        ctl_d.done  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end
                end else begin
                    miss_pulse = 1'b1;
                    ctl_d.vic  = victim_way;
                    vl         = int'(req_set) * WAYS + int'(victim_way);
                    if (ctl_q.we && !WRITE_BACK) begin
                        ctl_d.state = ST_WTHRU;
                    end else if (WRITE_BACK && valid_q[vl] && dirty_q[vl]) begin
                        ctl_d.state = ST_EVICT;
                    end else begin
                        ctl_d.state = ST_FILL;
                    end
                end
            end

            ST_EVICT: begin
                if (mem_ack) ctl_d.state = ST_FILL;
            end

            ST_FILL: begin
                if (mem_ack) begin
                    ctl_d.rdata = mem_rdata[int'(req_off)*DATA_W +: DATA_W];
                    if (ctl_q.we) line[int'(req_off)*DATA_W +: DATA_W] = ctl_q.wdata;
                    data_d[vl]  = line;
                    tag_d[vl]   = req_tag;
                    valid_d[vl] = 1'b1;
                    dirty_d[vl] = ctl_q.we;
                    touch_en    = 1'b1;
                    touch_way   = ctl_q.vic;
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end

            ST_WTHRU: begin
                if (mem_ack) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end

            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            valid_q     <= '0;
            dirty_q     <= '0;
        end else begin
            ctl_q   <= ctl_d;
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end

    // memory port decode
    always_comb begin
        int vl_o;
        vl_o      = int'(req_set) * WAYS + int'(ctl_q.vic);
        mem_req   = (ctl_q.state == ST_EVICT) || (ctl_q.state == ST_FILL)
                 || (ctl_q.state == ST_WTHRU);
        mem_we    = (ctl_q.state == ST_EVICT) || (ctl_q.state == ST_WTHRU);
        mem_blk   = req_blk;
        mem_wdata = {WORDS_PER_LINE{ctl_q.wdata}};
        mem_wstrb = '0;
        if (ctl_q.state == ST_EVICT) begin
            mem_blk   = BLK_W'((BLK_W'(tag_q[vl_o]) << IDX_W) | BLK_W'(req_set));
            mem_wdata = data_q[vl_o];
            mem_wstrb = '1;
        end else if (ctl_q.state == ST_WTHRU) begin
            mem_wstrb = WORDS_PER_LINE'(1) << req_off;
        end
    end

    assign cpu_ready = (ctl_q.state == ST_IDLE);
    assign cpu_done  = ctl_q.done;
    assign cpu_rdata = ctl_q.rdata;

    // R13: memory access fields held until acknowledged
    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_blk) && $stable(mem_we)));

    // R14: completion is a single-cycle pulse
    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R14: busy right after an accepted request
    a_r14_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready);

    // R4: write-through writes touch exactly one word
    a_r4_single_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!WRITE_BACK && mem_req && mem_we) |-> $countones(mem_wstrb) == 1);

    // R7: write-back mode writes memory only as whole lines
    a_r7_full_line_write: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && mem_req && mem_we) |-> (&mem_wstrb));

    // R3: at most one way of a set holds a given block
    a_r3_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: tb/assoc_cache_tb.sv
module cache_mem_model #(
    parameter int BLK_W  = 8,
    parameter int WPL    = 4,
    parameter int DATA_W = 32,
    parameter int LAT    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  we,
    input  logic [BLK_W-1:0]      blk,
    input  logic [WPL*DATA_W-1:0] wdata,
    input  logic [WPL-1:0]        wstrb,
    output logic                  ack,
    output logic [WPL*DATA_W-1:0] rdata
);
    localparam int NW = (1 << BLK_W) * WPL;

    logic [DATA_W-1:0] word_q [NW];
    int                cnt;
    int                wr_count;
    logic [WPL-1:0]    last_strb;
    logic [BLK_W-1:0]  last_rd_blk;
    logic [BLK_W-1:0]  last_wr_blk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NW; a++) word_q[a] <= 32'hC0DE0000 | 32'(a);
            cnt         <= 0;
            ack         <= 1'b0;
            rdata       <= '0;
            wr_count    <= 0;
            last_strb   <= '0;
            last_rd_blk <= '0;
            last_wr_blk <= '0;
        end else if (req && !ack) begin
            if (cnt == LAT - 1) begin
                cnt <= 0;
                ack <= 1'b1;
                if (we) begin
                    for (int i = 0; i < WPL; i++) begin
                        if (wstrb[i]) word_q[int'(blk) * WPL + i] <= wdata[i*DATA_W +: DATA_W];
                    end
                    wr_count    <= wr_count + 1;
                    last_strb   <= wstrb;
                    last_wr_blk <= blk;
                end else begin
                    for (int i = 0; i < WPL; i++) begin
                        rdata[i*DATA_W +: DATA_W] <= word_q[int'(blk) * WPL + i];
                    end
                    last_rd_blk <= blk;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end
endmodule

module assoc_cache_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int WPL    = 4;
    localparam int BLK_W  = 8;
    localparam int LINE_W = WPL * DATA_W;
    localparam int CNT_W  = 16;
    localparam int NWORDS = 1 << ADDR_W;
    localparam int NSTEP  = 14;

    // {we, addr, wdata, hit in write-back/LRU, hit in write-through/FIFO}
    localparam logic [44:0] STEPS [NSTEP] = '{
        {1'b0, 10'h000, 32'h0,        1'b0, 1'b0},  // cold miss (R12)
        {1'b0, 10'h003, 32'h0,        1'b1, 1'b1},  // same block hits (R3)
        {1'b0, 10'h010, 32'h0,        1'b0, 1'b0},  // second way of set 0
        {1'b0, 10'h001, 32'h0,        1'b1, 1'b1},  // first block kept (R9)
        {1'b0, 10'h020, 32'h0,        1'b0, 1'b0},  // LRU drops blk4, FIFO drops blk0
        {1'b0, 10'h002, 32'h0,        1'b1, 1'b0},  // policies differ (R10)
        {1'b1, 10'h005, 32'hAAAA0001, 1'b0, 1'b0},  // write miss
        {1'b0, 10'h005, 32'h0,        1'b1, 1'b0},  // allocated vs not (R5, R8)
        {1'b1, 10'h006, 32'hBBBB0002, 1'b1, 1'b1},  // write hit
        {1'b0, 10'h015, 32'h0,        1'b0, 1'b0},
        {1'b0, 10'h025, 32'h0,        1'b0, 1'b0},  // dirty eviction in write-back
        {1'b0, 10'h006, 32'h0,        1'b0, 1'b0},  // reads back written data
        {1'b0, 10'h004, 32'h0,        1'b1, 1'b1},
        {1'b0, 10'h030, 32'h0,        1'b0, 1'b0}   // fill of block 12 (R1)
    };

    logic clk = 1'b0;
    logic rst_n;
    logic req;
    logic we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    logic              rdy_a, done_a, mreq_a, mwe_a, mack_a;
    logic [DATA_W-1:0] rdata_a;
    logic [BLK_W-1:0]  mblk_a;
    logic [LINE_W-1:0] mwd_a, mrd_a;
    logic [WPL-1:0]    mstrb_a;
    logic [CNT_W-1:0]  hits_a, miss_a;

    logic              rdy_b, done_b, mreq_b, mwe_b, mack_b;
    logic [DATA_W-1:0] rdata_b;
    logic [BLK_W-1:0]  mblk_b;
    logic [LINE_W-1:0] mwd_b, mrd_b;
    logic [WPL-1:0]    mstrb_b;
    logic [CNT_W-1:0]  hits_b, miss_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] ref_mem [NWORDS];

    always #(CLK_P/2) clk = ~clk;

    assoc_cache #(.WRITE_BACK(1'b1), .USE_LRU(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_ready(rdy_a), .cpu_done(done_a), .cpu_rdata(rdata_a),
        .mem_req(mreq_a), .mem_we(mwe_a), .mem_blk(mblk_a), .mem_wdata(mwd_a),
        .mem_wstrb(mstrb_a), .mem_ack(mack_a), .mem_rdata(mrd_a),
        .hit_count(hits_a), .miss_count(miss_a)
    );

    assoc_cache #(.WRITE_BACK(1'b0), .USE_LRU(1'b0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_ready(rdy_b), .cpu_done(done_b), .cpu_rdata(rdata_b),
        .mem_req(mreq_b), .mem_we(mwe_b), .mem_blk(mblk_b), .mem_wdata(mwd_b),
        .mem_wstrb(mstrb_b), .mem_ack(mack_b), .mem_rdata(mrd_b),
        .hit_count(hits_b), .miss_count(miss_b)
    );

    cache_mem_model u_mem_a (
        .clk(clk), .rst_n(rst_n), .req(mreq_a), .we(mwe_a), .blk(mblk_a),
        .wdata(mwd_a), .wstrb(mstrb_a), .ack(mack_a), .rdata(mrd_a)
    );

    cache_mem_model u_mem_b (
        .clk(clk), .rst_n(rst_n), .req(mreq_b), .we(mwe_b), .blk(mblk_b),
        .wdata(mwd_b), .wstrb(mstrb_b), .ack(mack_b), .rdata(mrd_b)
    );

    function automatic logic [DATA_W-1:0] init_word(input int a);
        return 32'hC0DE0000 | 32'(a);
    endfunction

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        rst_n = 1'b0;
        for (int a = 0; a < NWORDS; a++) ref_mem[a] = init_word(a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check(rdy_a && rdy_b, "R12 ready after reset", {rdy_a, rdy_b}, 2'b11);
        check(!done_a && !done_b, "R12 done low after reset", {done_a, done_b}, 0);
        check(hits_a == 0 && miss_a == 0 && hits_b == 0 && miss_b == 0,
              "R12 counters zero", {hits_a, miss_a, hits_b, miss_b}, 0);

        for (int i = 0; i < NSTEP; i++) begin
            logic [44:0]       s;
            logic              s_we, s_hit_a, s_hit_b;
            logic [ADDR_W-1:0] s_addr;
            logic [DATA_W-1:0] s_wdata, exp;
            logic [CNT_W-1:0]  h0a, m0a, h0b, m0b;
            logic [DATA_W-1:0] rd_a, rd_b;
            bit                got_a, got_b, seen_a, seen_b;
            int                cyc_a, cyc_b, n;

            s       = STEPS[i];
            s_we    = s[44];
            s_addr  = s[43:34];
            s_wdata = s[33:2];
            s_hit_a = s[1];
            s_hit_b = s[0];
            exp     = ref_mem[s_addr];
            if (s_we) ref_mem[s_addr] = s_wdata;

            h0a = hits_a; m0a = miss_a; h0b = hits_b; m0b = miss_b;
            check(rdy_a && rdy_b, "R14 ready before request", {rdy_a, rdy_b}, 2'b11);
            req = 1'b1; we = s_we; addr = s_addr; wdata = s_wdata;
            @(negedge clk);
            req = 1'b0;
            n = 1;
            check(!rdy_a && !rdy_b, "R14 busy after request", {rdy_a, rdy_b}, 0);
            got_a = 0; got_b = 0; seen_a = 0; seen_b = 0;
            cyc_a = 0; cyc_b = 0; rd_a = '0; rd_b = '0;
            while (!(got_a && got_b) && n < 400) begin
                if (mreq_a && !got_a) seen_a = 1;
                if (mreq_b && !got_b) seen_b = 1;
                if (done_a && !got_a) begin got_a = 1; cyc_a = n; rd_a = rdata_a; end
                if (done_b && !got_b) begin got_b = 1; cyc_b = n; rd_b = rdata_b; end
                if (!(got_a && got_b)) begin
                    @(negedge clk);
                    n++;
                end
            end
            check(got_a && got_b, "R14 request completes", {got_a, got_b}, 2'b11);
            @(negedge clk);
            check(!done_a && !done_b, "R14 done is one cycle", {done_a, done_b}, 0);

            // R11 with R5 R8 R9 R10: exactly one counter moves, matching the expected class
            check((hits_a - h0a) == CNT_W'(s_hit_a) && (miss_a - m0a) == CNT_W'(!s_hit_a),
                  "R11 R8 R9 R10 hit/miss write-back LRU", {hits_a - h0a, miss_a - m0a},
                  {CNT_W'(s_hit_a), CNT_W'(!s_hit_a)});
            check((hits_b - h0b) == CNT_W'(s_hit_b) && (miss_b - m0b) == CNT_W'(!s_hit_b),
                  "R11 R5 R9 R10 hit/miss write-through FIFO", {hits_b - h0b, miss_b - m0b},
                  {CNT_W'(s_hit_b), CNT_W'(!s_hit_b)});

            // R2 for hits (two cycles, no memory), R3 for misses (memory used)
            if (s_hit_a) check(cyc_a == 2 && !seen_a, "R2 hit latency write-back", cyc_a, 2);
            else         check(seen_a, "R3 miss uses memory write-back", seen_a, 1);
            if (s_hit_b && !s_we) check(cyc_b == 2 && !seen_b, "R2 hit latency write-through", cyc_b, 2);
            else                  check(seen_b, "R3 R4 memory used write-through", seen_b, 1);

            if (!s_we) begin
                check(rd_a == exp, "R3 R8 read data write-back", rd_a, exp);
                check(rd_b == exp, "R3 R4 read data write-through", rd_b, exp);
            end

            if (i == 6) begin
                check(u_mem_b.word_q[5] == 32'hAAAA0001, "R4 write miss reaches memory",
                      u_mem_b.word_q[5], 32'hAAAA0001);
                check(u_mem_b.last_strb == 4'b0010, "R4 strobe at offset 1",
                      u_mem_b.last_strb, 4'b0010);
                check(u_mem_a.word_q[5] == init_word(5), "R6 R8 write-back memory untouched",
                      u_mem_a.word_q[5], init_word(5));
            end
            if (i == 8) begin
                check(u_mem_b.word_q[6] == 32'hBBBB0002, "R4 write hit reaches memory",
                      u_mem_b.word_q[6], 32'hBBBB0002);
                check(u_mem_a.word_q[6] == init_word(6), "R6 write hit stays in cache",
                      u_mem_a.word_q[6], init_word(6));
            end
            if (i == 10) begin
                check(u_mem_a.word_q[6] == 32'hBBBB0002 && u_mem_a.word_q[5] == 32'hAAAA0001,
                      "R7 dirty line written back", u_mem_a.word_q[6], 32'hBBBB0002);
                check(u_mem_a.last_strb == 4'hF, "R7 full line strobe",
                      u_mem_a.last_strb, 4'hF);
                check(u_mem_a.last_wr_blk == 8'd1, "R1 R7 victim block number",
                      u_mem_a.last_wr_blk, 8'd1);
            end
        end

        check(u_mem_a.wr_count == 1, "R7 clean victims not written", u_mem_a.wr_count, 1);
        check(u_mem_b.wr_count == 2, "R4 one memory write per write", u_mem_b.wr_count, 2);
        check(u_mem_a.last_rd_blk == 8'd12, "R1 fill block number", u_mem_a.last_rd_blk, 8'd12);
        check(hits_a == 6 && miss_a == 8, "R11 totals write-back LRU", {hits_a, miss_a},
              {16'd6, 16'd8});
        check(hits_b == 4 && miss_b == 10, "R11 totals write-through FIFO", {hits_b, miss_b},
              {16'd4, 16'd10});

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule